// File: doc/BRIEF.md
# Packed Unsigned Saturating Subtractor

This unit is a SIMD datapath stage. It subtracts every lane of a second 256-bit operand from the matching lane of a first 256-bit operand. When a lane difference would drop below zero, that lane's result is held at zero. A lane-size select chooses 8-bit or 16-bit unsigned lanes. A width-mode select chooses one of three active widths: 64, 128 or 256 bits.

The result bits above the active width come from one of two places. In the 64-bit mode and in the preserving 128-bit mode they are copied from the old destination value. In the clearing 128-bit mode they are forced to zero. The result and a valid flag are registered one clock after an accepted input. An unsupported lane-size code produces a one-cycle error pulse instead of a result.

Top module: `psub_sat_unit`

## Requirements
- R1: With `lane_sel` = 2'b00 (byte lanes), each 8-bit lane of the result is `op_a` lane minus `op_b` lane when `op_a` ≥ `op_b`, and 8'h00 otherwise.
- R2: With `lane_sel` = 2'b01 (word lanes), each 16-bit lane of the result is `op_a` lane minus `op_b` lane when `op_a` ≥ `op_b`, and 16'h0000 otherwise.
- R3: A lane's result depends only on that lane's bits of both operands. No borrow passes into the next lane up.
- R4: With `width_mode` = 2'b00 (64-bit), result bits 63:0 are computed and bits 255:64 equal `dest_old` bits 255:64.
- R5: With `width_mode` = 2'b01 (128-bit, preserve), result bits 127:0 are computed and bits 255:128 equal `dest_old` bits 255:128.
- R6: With `width_mode` = 2'b10 (128-bit, clear), result bits 127:0 are computed and bits 255:128 are zero.
- R7: With `width_mode` = 2'b11 (256-bit), all 256 result bits are computed lane by lane.
- R8: A `lane_sel` value of 2'b10 or 2'b11 with `in_valid` high gives `out_valid` low and `err_pulse` high on the next cycle, and leaves `result` unchanged.
- R9: A legal input with `in_valid` high gives `out_valid` high and the new `result` exactly one clock later. A cycle with `in_valid` low gives `out_valid` low and leaves `result` unchanged.
- R10: While `rst_n` is low at a clock edge, `result`, `out_valid` and `err_pulse` are all cleared to zero.
- R11: The result is never clamped at the top. A lane equal to the maximum minus zero gives the maximum, and no lane result ever exceeds its `op_a` lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_a | input | 256 | Minuend vector |
| op_b | input | 256 | Subtrahend vector |
| dest_old | input | 256 | Previous destination contents, used for the preserved upper bits |
| lane_sel | input | 2 | 00 byte lanes, 01 word lanes, 1x unsupported |
| width_mode | input | 2 | 00 64-bit, 01 128-bit preserve, 10 128-bit clear, 11 256-bit |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 256 | Registered packed difference |
| err_pulse | output | 1 | Previous input had an unsupported lane-size code |

## Verification
Every result, valid flag and error pulse is due on the clock edge that follows the cycle in which its input was presented, with no other pipeline stage in between. The driver applies inputs on the falling edge and pushes one expected item per cycle, including idle cycles, into the scoreboard. The monitor pops one item per rising edge and samples the outputs a short delay after that edge. Because of this, an item is compared in exactly the cycle its input should have reached the register. An item that arrived late or early would fail its comparison.

// File: rtl/psub_pkg.sv
// Package: shared encodings for the packed saturating subtractor.
// Assumes: a 2-bit lane-size code and a 2-bit width-mode code.
package psub_pkg;
    localparam logic [1:0] LS_BYTE = 2'b00;
    localparam logic [1:0] LS_WORD = 2'b01;

    typedef enum logic [1:0] {
        WM_64       = 2'b00,
        WM_128_KEEP = 2'b01,
        WM_128_ZERO = 2'b10,
        WM_256      = 2'b11
    } width_mode_e;
endpackage

// File: rtl/psub_sat_lane.sv
// Module: one unsigned lane, a minus b, floored at zero.
// Assumes: W-bit unsigned operands. An extra borrow bit flags a negative difference.
module psub_sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] diff;

    // Widened subtraction and clamp on borrow.
    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        y    = diff[W] ? '0 : diff[W-1:0];
    end
endmodule

// File: rtl/psub_lane_array.sv
// Module: replicates the saturating lane across a full vector.
// Assumes: DW is a multiple of LW. The lanes are fully independent.
module psub_lane_array #(
    parameter int DW = 256,
    parameter int LW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    localparam int NLANES = DW / LW;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        psub_sat_lane #(.W(LW)) u_lane (
            .a (a[i*LW +: LW]),
            .b (b[i*LW +: LW]),
            .y (y[i*LW +: LW])
        );
    end
endmodule

// File: rtl/psub_width_merge.sv
// Module: picks, chunk by chunk, between fresh lane results, old destination bits and zero.
// Assumes: NARROW_W, MID_W and DW are multiples of CW.
module psub_width_merge
    import psub_pkg::*;
#(
    parameter int DW       = 256,
    parameter int CW       = 64,
    parameter int NARROW_W = 64,
    parameter int MID_W    = 128
) (
    input  width_mode_e   mode,
    input  logic [DW-1:0] fresh,
    input  logic [DW-1:0] old,
    output logic [DW-1:0] merged
);
    localparam int NCH   = DW / CW;
    localparam int CNT_W = $clog2(NCH + 1);

    logic [CNT_W-1:0] live_chunks;
    logic             fill_old;

    // Decode the mode into an active chunk count and the fill source.
    always_comb begin
        case (mode)
            WM_64: begin
                live_chunks = CNT_W'(NARROW_W / CW);
                fill_old    = 1'b1;
            end
            WM_128_KEEP: begin
                live_chunks = CNT_W'(MID_W / CW);
                fill_old    = 1'b1;
            end
            WM_128_ZERO: begin
                live_chunks = CNT_W'(MID_W / CW);
                fill_old    = 1'b0;
            end
            default: begin
                live_chunks = CNT_W'(NCH);
                fill_old    = 1'b0;
            end
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        // Choose the source of this chunk.
        always_comb begin
            if (CNT_W'(c) < live_chunks)
                merged[c*CW +: CW] = fresh[c*CW +: CW];
            else if (fill_old)
                merged[c*CW +: CW] = old[c*CW +: CW];
            else
                merged[c*CW +: CW] = '0;
        end
    end
endmodule

// File: rtl/psub_sat_unit.sv
// Module: top of the packed unsigned saturating subtractor. It holds the
// byte and word lane arrays, the width merge and the output register.
// Assumes: inputs are stable around the rising edge. Reset is synchronous, active low.
module psub_sat_unit
    import psub_pkg::*;
#(
    parameter int VEC_W    = 256,
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 16,
    parameter int CHUNK_W  = 64,
    parameter int NARROW_W = 64,
    parameter int MID_W    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic [VEC_W-1:0] dest_old,
    input  logic [1:0]       lane_sel,
    input  logic [1:0]       width_mode,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             err_pulse
);
    localparam int NBYTES = VEC_W / BYTE_W;

    logic [VEC_W-1:0] byte_res;
    logic [VEC_W-1:0] word_res;
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] merged;
    logic             lane_legal;

    psub_lane_array #(.DW(VEC_W), .LW(BYTE_W)) u_bytes (
        .a (op_a), .b (op_b), .y (byte_res)
    );

    psub_lane_array #(.DW(VEC_W), .LW(WORD_W)) u_words (
        .a (op_a), .b (op_b), .y (word_res)
    );

    // Check the lane-size code and select the lane array.
    always_comb begin
        lane_legal = (lane_sel == LS_BYTE) || (lane_sel == LS_WORD);
        lane_res   = (lane_sel == LS_WORD) ? word_res : byte_res;
    end

    psub_width_merge #(
        .DW(VEC_W), .CW(CHUNK_W), .NARROW_W(NARROW_W), .MID_W(MID_W)
    ) u_merge (
        .mode   (width_mode_e'(width_mode)),
        .fresh  (lane_res),
        .old    (dest_old),
        .merged (merged)
    );

    // Output register: capture on a legal input, pulse the error flag on an illegal one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            out_valid <= in_valid && lane_legal;
            err_pulse <= in_valid && !lane_legal;
            if (in_valid && lane_legal)
                result <= merged;
        end
    end

    assert_illegal_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel[1]) |=> (!out_valid && err_pulse && $stable(result)));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_sel[1]) |=> out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !err_pulse && $stable(result)));

    assert_keep_upper_64_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_sel[1] && width_mode == WM_64) |=>
        (result[VEC_W-1:NARROW_W] == $past(dest_old[VEC_W-1:NARROW_W])));

    assert_keep_upper_128_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_sel[1] && width_mode == WM_128_KEEP) |=>
        (result[VEC_W-1:MID_W] == $past(dest_old[VEC_W-1:MID_W])));

    assert_zero_upper_128_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_sel[1] && width_mode == WM_128_ZERO) |=>
        (result[VEC_W-1:MID_W] == '0));

    for (genvar i = 0; i < NBYTES; i++) begin : g_chk
        assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
            byte_res[i*BYTE_W +: BYTE_W] <= op_a[i*BYTE_W +: BYTE_W]);
    end
endmodule

// File: tb/psub_sat_unit_tb.sv
// Scoreboard bench: the driver pushes one expected item per cycle, and the monitor pops and compares.
module psub_sat_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] op_a = '0, op_b = '0, dest_old = '0;
    logic [1:0]   lane_sel = 2'b00, width_mode = 2'b00;
    logic         out_valid, err_pulse;
    logic [255:0] result;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct packed { logic v; logic e; logic [255:0] r; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [255:0] m_res = '0;

    always #4 clk = ~clk;

    psub_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .dest_old(dest_old), .lane_sel(lane_sel), .width_mode(width_mode),
        .out_valid(out_valid), .result(result), .err_pulse(err_pulse)
    );

    function automatic logic [255:0] model(input logic [255:0] a, b, d,
                                           input logic [1:0] ls, wm);
        logic [255:0] r;
        if (ls == 2'b00) begin
            for (int i = 0; i < 32; i++)
                r[i*8 +: 8] = (a[i*8 +: 8] >= b[i*8 +: 8]) ? a[i*8 +: 8] - b[i*8 +: 8] : 8'h00;
        end else begin
            for (int i = 0; i < 16; i++)
                r[i*16 +: 16] = (a[i*16 +: 16] >= b[i*16 +: 16]) ? a[i*16 +: 16] - b[i*16 +: 16] : 16'h0000;
        end
        case (wm)
            2'b00: r[255:64]  = d[255:64];
            2'b01: r[255:128] = d[255:128];
            2'b10: r[255:128] = '0;
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic v, input logic [255:0] a, b, d,
                         input logic [1:0] ls, wm, input string tag);
        exp_t x;
        @(negedge clk);
        in_valid = v; op_a = a; op_b = b; dest_old = d; lane_sel = ls; width_mode = wm;
        x.v = v && !ls[1];
        x.e = v && ls[1];
        if (x.v) m_res = model(a, b, d, ls, wm);
        x.r = m_res;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, '1, '0, '1, 2'b00, 2'b11, tag);
    endtask

    // Monitor: compare one item a short time after every rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " out_valid"}, {255'd0, out_valid}, {255'd0, x.v});
            check({t, " err_pulse"}, {255'd0, err_pulse}, {255'd0, x.e});
            check({t, " result"}, result, x.r);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] pa, pb, pd;
        pa = {8{32'hF0E1_D2C3}} ^ {4{64'h0123_4567_89AB_CDEF}};
        pb = {8{32'h1F2E_3D4C}};
        pd = {16{16'hA5C3}};
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset out_valid", {255'd0, out_valid}, '0);
        check("R10 reset err_pulse", {255'd0, err_pulse}, '0);
        check("R10 reset result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9 idle after reset");
        drive(1'b1, pa, pb, pd, 2'b00, 2'b11, "R1 R7 bytes 256");
        drive(1'b1, pa, pb, pd, 2'b01, 2'b11, "R2 R7 words 256");
        drive(1'b1, pb, pa, pd, 2'b00, 2'b11, "R1 swapped bytes");
        drive(1'b1, {16{16'h0100}}, {16{16'h0001}}, pd, 2'b00, 2'b11, "R3 no borrow bytes");
        drive(1'b1, {16{16'h0100}}, {16{16'h0001}}, pd, 2'b01, 2'b11, "R3 word borrow inside");
        drive(1'b1, pa, pb, pd, 2'b00, 2'b00, "R4 64-bit bytes");
        drive(1'b1, pa, pb, pd, 2'b01, 2'b00, "R4 64-bit words");
        drive(1'b1, pa, pb, pd, 2'b00, 2'b01, "R5 128 keep");
        drive(1'b1, pa, pb, pd, 2'b01, 2'b10, "R6 128 clear");
        drive(1'b1, '1, '0, pd, 2'b00, 2'b11, "R11 max minus zero");
        drive(1'b1, pa, pa, pd, 2'b01, 2'b11, "R1 R2 equal operands");
        drive(1'b1, '0, '1, pd, 2'b01, 2'b11, "R2 full underflow");
        drive(1'b1, pa, pb, pd, 2'b10, 2'b11, "R8 illegal 10");
        drive(1'b1, pb, pa, pd, 2'b11, 2'b01, "R8 illegal 11");
        idle("R9 hold after illegal");
        drive(1'b1, pb, pa, pd, 2'b01, 2'b01, "R5 R9 after idle");
        idle("R9 hold");
        idle("R9 hold again");
        drive(1'b1, {32{8'h80}}, {32{8'h81}}, pd, 2'b00, 2'b10, "R1 R6 off by one");
        idle("R9 final");
        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule